// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is one timer channel. Software programs it through a small register port. The channel counts down on a tick input, optionally slowed by a prescaler, and raises a level interrupt each time the count expires. A two-state machine (`ST_IDLE`, `ST_RUN`) decides whether the counter advances. The transitions are:

- START: a control write with the enable bit set moves `ST_IDLE` to `ST_RUN`.
- STOP: a control write with the enable bit clear moves `ST_RUN` to `ST_IDLE`.
- ONESHOT_DONE: an expiry in one-shot mode moves `ST_RUN` to `ST_IDLE`.

A control write with the enable bit set while the channel is already in `ST_RUN` keeps it in `ST_RUN`.

Three counting modes exist:

- Free-running: the counter wraps to the maximum value of the selected width.
- Periodic: the counter reloads from the load register.
- One-shot: the counter halts at zero.

The counter is either 16 or 32 bits wide. After reset the channel is stopped and its interrupt is already enabled. The register port is single-cycle: a write takes effect at the clock edge where `wr_en` is high, and `rd_data` is a combinational view of the register selected by `addr`.

Top module: `dtimer_chan`

## Requirements
- R1: After reset the control register reads 0x02 (only the interrupt-enable bit set), the channel is in `ST_IDLE`, COUNT reads 0, raw status reads 0 and `irq` is low.
- R2: Register map, by word index on `addr`: 0 CTRL (read/write), 1 LOAD (read/write), 2 COUNT (read-only), 3 CLEAR (write-only, reads 0), 4 RAW status (bit 0), 5 MASKED status (bit 0). CTRL fields: bit 0 enable (reads 1 in `ST_RUN`), bit 1 interrupt enable, bit 2 32-bit size, bit 3 periodic, bit 4 one-shot, bits 6:5 prescale. The other bits and addresses read 0.
- R3: Free-running mode (bits 3 and 4 both clear): a prescaled step at count 0 wraps the count to 0xFFFF when 16-bit or 0xFFFFFFFF when 32-bit, and sets raw status.
- R4: Periodic mode (bit 3 set, bit 4 clear): a step at count 0 reloads the count from LOAD, masked to the width, and sets raw status. Every other step decrements the count by one.
- R5: One-shot mode (bit 4 set; this wins over bit 3): a step at count 0 sets raw status, keeps the count at 0, clears the CTRL enable bit and enters `ST_IDLE`.
- R6: Prescale value 0 or 3 steps on every tick, 1 on every 16th tick and 2 on every 256th tick. The prescaler restarts on any CTRL or LOAD write and while the channel is idle. Cycles with `tick` low never count.
- R7: A LOAD write stores the value and sets COUNT to the active limit: the LOAD value masked to the width in periodic or one-shot mode, or the width's maximum in free-running mode. This applies whether the channel is running or not.
- R8: A CTRL write with enable set reloads COUNT with the limit under the newly written settings and counts at the new prescale rate. A CTRL write with enable clear stops the channel and leaves COUNT unchanged.
- R9: In 16-bit mode only the low 16 bits of the counter are used: COUNT reads 0 in bits 31:16.
- R10: A CLEAR write clears raw status. If an expiry happens in the same cycle, the expiry wins.
- R11: `irq` equals raw status AND the interrupt-enable bit. RAW reads the pending state whatever the enable setting. MASKED reads `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count tick qualifier |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (3) | Register word index |
| wr_data | input | CW (32) | Write data |
| rd_data | output | CW (32) | Read data for `addr` |
| irq | output | 1 | Level interrupt |

## Verification
The main counting function is driven in each of the three modes:

- Periodic mode with a short load value, which separates reload-from-LOAD from a wrap to the maximum.
- One-shot mode with both mode bits set, which shows that one-shot takes priority and that the enable bit is cleared.
- A full 16-bit free-running pass, which shows the wrap to the width's maximum rather than to LOAD.
- A 32-bit free-running start, which shows the 32-bit maximum.

The prescaler is tried at each setting with runs one tick short of a step and then one tick past it. Gaps with `tick` low show that idle cycles never count. Loads wider than 16 bits, followed by narrowing the size, show the width masking. Disabled writes show that a stopped channel holds its count.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

    // register word indices
    localparam int A_CTRL  = 0;
    localparam int A_LOAD  = 1;
    localparam int A_COUNT = 2;
    localparam int A_CLEAR = 3;
    localparam int A_RAW   = 4;
    localparam int A_MASK  = 5;

    // control field positions
    localparam int B_EN    = 0;
    localparam int B_IEN   = 1;
    localparam int B_WIDE  = 2;
    localparam int B_PER   = 3;
    localparam int B_ONE   = 4;
    localparam int B_PS_LO = 5;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'd0,
        PS_DIV16  = 2'd1,
        PS_DIV256 = 2'd2,
        PS_RSVD   = 2'd3
    } psc_sel_e;

    typedef struct packed {
        psc_sel_e presc;
        logic     oneshot;
        logic     periodic;
        logic     wide;
        logic     ien;
    } ctl_t;

endpackage

// File: rtl/dtimer_prescale.sv
module dtimer_prescale
    import dtimer_pkg::*;
#(
    parameter int PSC_W     = 8,
    parameter int DIV_A_LOG = 4,
    parameter int DIV_B_LOG = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     tick,
    input  psc_sel_e sel,
    output logic     step
);
    localparam logic [PSC_W-1:0] MASK_A = PSC_W'((1 << DIV_A_LOG) - 1);
    localparam logic [PSC_W-1:0] MASK_B = PSC_W'((1 << DIV_B_LOG) - 1);

    logic [PSC_W-1:0] psc_q;
    logic             hit;

    always_comb begin
        unique case (sel)
            PS_DIV16:  hit = (psc_q & MASK_A) == MASK_A;
            PS_DIV256: hit = (psc_q & MASK_B) == MASK_B;
            default:   hit = 1'b1;
        endcase
    end

    assign step = tick && hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (clr) begin
            psc_q <= '0;
        end else if (tick) begin
            psc_q <= psc_q + 1'b1;
        end
    end

endmodule

// File: rtl/dtimer_core.sv
module dtimer_core
    import dtimer_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          reload,
    input  logic [CW-1:0] reload_val,
    input  logic          start,
    input  logic          start_en,
    input  logic          oneshot,
    input  logic [CW-1:0] wrap_val,
    input  logic [CW-1:0] cnt_mask,
    input  logic          clr_raw,
    output logic [CW-1:0] count,
    output logic          running,
    output logic          raw
);
    run_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          raw_q;
    logic          at_zero;
    logic          advance;
    logic          expire;

    assign at_zero = (cnt_q & cnt_mask) == '0;
    assign advance = (state_q == ST_RUN) && step && !start && !reload;
    assign expire  = advance && at_zero;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: START, STOP, ONESHOT_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start && start_en) state_d = ST_RUN;
            ST_RUN: begin
                if (start && !start_en)      state_d = ST_IDLE;
                else if (expire && oneshot)  state_d = ST_IDLE;
            end
        endcase
    end

    // counter and raw status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            raw_q <= 1'b0;
        end else begin
            if (reload) begin
                cnt_q <= reload_val;
            end else if (advance) begin
                if (at_zero) cnt_q <= oneshot ? '0 : wrap_val;
                else         cnt_q <= (cnt_q - 1'b1) & cnt_mask;
            end
            if (expire)       raw_q <= 1'b1;
            else if (clr_raw) raw_q <= 1'b0;
        end
    end

    assign count   = cnt_q & cnt_mask;
    assign running = (state_q == ST_RUN);
    assign raw     = raw_q;

endmodule

// File: rtl/dtimer_chan.sv
module dtimer_chan
    import dtimer_pkg::*;
#(
    parameter int CW        = 32,
    parameter int NW        = 16,
    parameter int AW        = 3,
    parameter int PSC_W     = 8,
    parameter int DIV_A_LOG = 4,
    parameter int DIV_B_LOG = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] rd_data,
    output logic          irq
);
    localparam logic [CW-1:0] FULL   = '1;
    localparam logic [CW-1:0] NARROW = {{(CW-NW){1'b0}}, {NW{1'b1}}};

    ctl_t          ctl_q, ctl_new;
    logic [CW-1:0] load_q;
    logic          wr_ctl, wr_ld, wr_clr;
    logic          reload;
    logic [CW-1:0] reload_val, wrap_val, cnt_mask, count;
    logic          running, raw, presc_step;

    function automatic logic [CW-1:0] limit_of(ctl_t c, logic [CW-1:0] ld);
        logic [CW-1:0] m;
        m = c.wide ? FULL : NARROW;
        return (c.periodic || c.oneshot) ? (ld & m) : m;
    endfunction

    assign wr_ctl = wr_en && (addr == AW'(A_CTRL));
    assign wr_ld  = wr_en && (addr == AW'(A_LOAD));
    assign wr_clr = wr_en && (addr == AW'(A_CLEAR));

    always_comb begin
        ctl_new.presc    = psc_sel_e'(wr_data[B_PS_LO +: 2]);
        ctl_new.oneshot  = wr_data[B_ONE];
        ctl_new.periodic = wr_data[B_PER];
        ctl_new.wide     = wr_data[B_WIDE];
        ctl_new.ien      = wr_data[B_IEN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '{presc: PS_DIV1, oneshot: 1'b0, periodic: 1'b0,
                        wide: 1'b0, ien: 1'b1};
            load_q <= '0;
        end else begin
            if (wr_ctl) ctl_q  <= ctl_new;
            if (wr_ld)  load_q <= wr_data;
        end
    end

    assign reload     = wr_ld || (wr_ctl && wr_data[B_EN]);
    assign reload_val = wr_ld ? limit_of(ctl_q, wr_data) : limit_of(ctl_new, load_q);
    assign wrap_val   = limit_of(ctl_q, load_q);
    assign cnt_mask   = ctl_q.wide ? FULL : NARROW;

    dtimer_prescale #(
        .PSC_W(PSC_W), .DIV_A_LOG(DIV_A_LOG), .DIV_B_LOG(DIV_B_LOG)
    ) u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (wr_ld || wr_ctl || !running),
        .tick (tick),
        .sel  (ctl_q.presc),
        .step (presc_step)
    );

    dtimer_core #(.CW(CW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (presc_step),
        .reload    (reload),
        .reload_val(reload_val),
        .start     (wr_ctl),
        .start_en  (wr_data[B_EN]),
        .oneshot   (ctl_q.oneshot),
        .wrap_val  (wrap_val),
        .cnt_mask  (cnt_mask),
        .clr_raw   (wr_clr),
        .count     (count),
        .running   (running),
        .raw       (raw)
    );

    assign irq = raw && ctl_q.ien;

    always_comb begin
        rd_data = '0;
        unique case (addr)
            AW'(A_CTRL): begin
                rd_data[B_EN]          = running;
                rd_data[B_IEN]         = ctl_q.ien;
                rd_data[B_WIDE]        = ctl_q.wide;
                rd_data[B_PER]         = ctl_q.periodic;
                rd_data[B_ONE]         = ctl_q.oneshot;
                rd_data[B_PS_LO +: 2]  = ctl_q.presc;
            end
            AW'(A_LOAD):  rd_data = load_q;
            AW'(A_COUNT): rd_data = count;
            AW'(A_RAW):   rd_data[0] = raw;
            AW'(A_MASK):  rd_data[0] = irq;
            default:      rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dtimer_chan_chk.sv
module dtimer_chan_chk
    import dtimer_pkg::*;
#(
    parameter int CW = 32,
    parameter int NW = 16,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic          irq,
    input ctl_t          ctl_q,
    input logic [CW-1:0] load_q,
    input logic [CW-1:0] count,
    input logic          running,
    input logic          raw,
    input logic          presc_step
);
    logic [CW-1:0] mask;
    logic          expiring;
    assign mask     = ctl_q.wide ? {CW{1'b1}} : {{(CW-NW){1'b0}}, {NW{1'b1}}};
    assign expiring = running && presc_step && (count == '0) && !wr_en;

    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.ien |-> !irq);

    p_irq_follows_raw_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && ctl_q.ien) |-> irq);

    p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expiring && ctl_q.oneshot) |=> (!running && raw && count == '0));

    p_periodic_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expiring && ctl_q.periodic && !ctl_q.oneshot)
        |=> (raw && count == $past(load_q & mask)));

    p_free_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (expiring && !ctl_q.periodic && !ctl_q.oneshot)
        |=> (raw && count == $past(mask)));

    p_narrow_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.wide |-> (count[CW-1:NW] == '0));

    p_clear_raw_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(A_CLEAR) && !(running && presc_step && count == '0))
        |=> !raw);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_en) |=> $stable(count));

endmodule

bind dtimer_chan dtimer_chan_chk #(.CW(CW), .NW(NW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .irq       (irq),
    .ctl_q     (ctl_q),
    .load_q    (load_q),
    .count     (count),
    .running   (running),
    .raw       (raw),
    .presc_step(presc_step)
);

// File: tb/dtimer_chan_tb_top.sv
module dtimer_chan_tb_top;
    localparam int CW = 32;
    localparam int AW = 3;
    localparam int I_CTRL = 0, I_LOAD = 1, I_COUNT = 2, I_CLEAR = 3,
                   I_RAW = 4, I_MASK = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] rd_data;
    logic          irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    dtimer_chan dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [CW-1:0] v);
        @(negedge clk);
        addr = AW'(a);
        #1;
        v = rd_data;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input int a, input logic [CW-1:0] exp);
        logic [CW-1:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic t_reset;
        expect_reg("R1 ctrl after reset", I_CTRL, 32'h2);
        expect_reg("R1 count after reset", I_COUNT, 32'h0);
        expect_reg("R1 raw after reset", I_RAW, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_periodic;
        wr(I_LOAD, 32'd5);
        expect_reg("R7 load in free mode sets max", I_COUNT, 32'hFFFF);
        wr(I_CTRL, 32'h0B);
        expect_reg("R8 start reloads limit", I_COUNT, 32'd5);
        expect_reg("R2 ctrl readback", I_CTRL, 32'h0B);
        ticks(3);
        expect_reg("R4 decrement", I_COUNT, 32'd2);
        ticks(2);
        expect_reg("R4 at zero", I_COUNT, 32'd0);
        expect_reg("R4 no raw before expiry", I_RAW, 32'd0);
        ticks(1);
        expect_reg("R4 reload from LOAD", I_COUNT, 32'd5);
        expect_reg("R4 raw set", I_RAW, 32'd1);
        chk("R11 irq high", {31'b0, irq}, 32'h1);
        expect_reg("R11 masked status", I_MASK, 32'd1);
        wr(I_CLEAR, 32'h0);
        expect_reg("R10 raw cleared", I_RAW, 32'd0);
        chk("R10 irq low after clear", {31'b0, irq}, 32'h0);
        ticks(6);
        expect_reg("R4 second period raw", I_RAW, 32'd1);
        expect_reg("R4 second period count", I_COUNT, 32'd5);
        wr(I_CLEAR, 32'h0);
        wr(I_CTRL, 32'h0A);
        ticks(4);
        expect_reg("R8 stopped holds count", I_COUNT, 32'd5);
    endtask

    task automatic t_oneshot;
        wr(I_LOAD, 32'd3);
        expect_reg("R7 load while idle", I_COUNT, 32'd3);
        wr(I_CTRL, 32'h19);
        ticks(3);
        expect_reg("R5 reached zero", I_COUNT, 32'd0);
        expect_reg("R5 no raw at zero", I_RAW, 32'd0);
        ticks(1);
        expect_reg("R5 enable cleared", I_CTRL, 32'h18);
        expect_reg("R11 raw visible while masked", I_RAW, 32'd1);
        expect_reg("R11 masked status low", I_MASK, 32'd0);
        chk("R11 irq masked", {31'b0, irq}, 32'h0);
        ticks(3);
        expect_reg("R5 holds zero", I_COUNT, 32'd0);
        wr(I_CLEAR, 32'h0);
        expect_reg("R10 clear after one-shot", I_RAW, 32'd0);
    endtask

    task automatic t_prescale;
        wr(I_CTRL, 32'h0A);
        wr(I_LOAD, 32'd100);
        wr(I_CTRL, 32'h29);
        ticks(15);
        expect_reg("R6 div16 one short", I_COUNT, 32'd100);
        ticks(1);
        expect_reg("R6 div16 step", I_COUNT, 32'd99);
        ticks(16);
        expect_reg("R6 div16 second step", I_COUNT, 32'd98);
        repeat (5) @(negedge clk);
        ticks(15);
        expect_reg("R6 idle cycles not counted", I_COUNT, 32'd98);
        ticks(1);
        expect_reg("R6 div16 after gap", I_COUNT, 32'd97);
        wr(I_CTRL, 32'h49);
        expect_reg("R8 rate change reloads", I_COUNT, 32'd100);
        ticks(255);
        expect_reg("R6 div256 one short", I_COUNT, 32'd100);
        ticks(1);
        expect_reg("R6 div256 step", I_COUNT, 32'd99);
        wr(I_CTRL, 32'h69);
        ticks(2);
        expect_reg("R6 value 3 undivided", I_COUNT, 32'd98);
        expect_reg("R2 prescale readback", I_CTRL, 32'h69);
        wr(I_CTRL, 32'h08);
    endtask

    task automatic t_width;
        wr(I_CTRL, 32'h0C);
        wr(I_LOAD, 32'h0001_2345);
        expect_reg("R7 wide periodic load", I_COUNT, 32'h0001_2345);
        wr(I_CTRL, 32'h08);
        expect_reg("R9 narrow count view", I_COUNT, 32'h0000_2345);
        wr(I_LOAD, 32'h0001_0003);
        expect_reg("R9 narrow load masked", I_COUNT, 32'h3);
        wr(I_CTRL, 32'h04);
        wr(I_LOAD, 32'd7);
        expect_reg("R3 wide free max", I_COUNT, 32'hFFFF_FFFF);
        wr(I_CTRL, 32'h05);
        ticks(1);
        expect_reg("R3 wide free counts down", I_COUNT, 32'hFFFF_FFFE);
        wr(I_CTRL, 32'h04);
    endtask

    task automatic t_free16;
        wr(I_CTRL, 32'h03);
        expect_reg("R3 narrow free start", I_COUNT, 32'hFFFF);
        ticks(65535);
        expect_reg("R3 narrow free at zero", I_COUNT, 32'h0);
        expect_reg("R3 no raw before wrap", I_RAW, 32'h0);
        ticks(1);
        expect_reg("R3 wraps to max not LOAD", I_COUNT, 32'hFFFF);
        expect_reg("R3 raw on wrap", I_RAW, 32'h1);
        chk("R11 irq on wrap", {31'b0, irq}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_periodic();
        t_oneshot();
        t_prescale();
        t_width();
        t_free16();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule